// File: doc/BRIEF.md
# Break-Gated Two-Step Status Flag Unit

This block holds the status flags of a peripheral. Hardware events set the flags. Software clears them in two steps:

1. It reads the status register while a flag is set, which arms that flag.
2. It then reads or writes the data register, which clears every armed flag.

Each flag keeps its own arm bit, so a flag that becomes set after the status read is not lost by the step-two access.

A debugger-driven break input can freeze this clearing. A clear-enable configuration bit decides the policy during a break:

- **Clear-enable at 0 (the reset value):** bus traffic during a break is harmless. It neither arms nor clears any flag, and arming done before the break is kept.
- **Clear-enable at 1:** software may arm and clear flags during the break, and what it clears stays cleared after the break ends.

The serial engine that raises the events and the bus address decoder lie outside the block.

Top module: `sfc_status_unit`

## Requirements
- R1: A set event on `set_evt[i]` makes `flags_o[i]` 1 at the clock edge that samples it.
- R2: Reset (`rst_n` low) forces all flags to 0, all arm bits to 0 and `clr_en_o` to 0.
- R3: A read with `reg_sel`=0 (the status register) arms every flag that is 1 at that moment. A later read or write with `reg_sel`=1 (the data register) then clears the armed flags at the next edge.
- R4: A cycle with `cfg_wr`=1 loads `cfg_val` into the clear-enable bit, visible on `clr_en_o` after that edge.
- R5: While `brk_i`=1 and clear-enable is 0, data-register accesses leave every flag unchanged.
- R6: A status read made while `brk_i`=1 and clear-enable is 0 arms nothing, so a data access after the break leaves such a flag set.
- R7: Arming done before a break is kept through the break, and a data access after the break clears the flag.
- R8: With clear-enable 1, a status read and a data access during a break clear a flag, and it stays 0 after the break.
- R9: A set event in the same cycle as a completing data access leaves the flag at 1 and cancels its arming. A later data access without a new status read leaves it at 1.
- R10: Arming captures the flag values held before the read. A flag set in or after the read cycle is not cleared by the next data access, and a write to the status register arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_evt | input | NUM_FLAGS | Hardware set events, one per flag |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| reg_sel | input | 1 | 0 selects the status register, 1 the data register |
| brk_i | input | 1 | Debug break state from the system controller |
| cfg_wr | input | 1 | Load strobe for the clear-enable bit |
| cfg_val | input | 1 | Value loaded into the clear-enable bit |
| clr_en_o | output | 1 | Current clear-enable bit |
| flags_o | output | NUM_FLAGS | Status flags |

## Verification
The bench targets four corner cases.

- **Step-one read inside a frozen break.** A design that arms on this read would clear the flag on the first data access after the break.
- **A flag armed before the break and accessed during it.** A design that drops or consumes the arm during the break would leave the flag set after the break, or clear it early.
- **A set event in the same cycle as a completing access, and a set just after the status read.** A design that favours the clear, or that re-samples flags at step two, would lose a fresh event.
- **A status-register write and a reset taken while armed.** A design that arms on writes, or that keeps arms through reset, would clear flags that software never acknowledged.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic flag;
        logic arm;
    } cell_state_t;

    typedef struct packed {
        logic arm_stb;
        logic clr_stb;
        logic gate_ok;
    } access_t;

endpackage

// File: rtl/sfc_cfg_reg.sv
module sfc_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_val,
    output logic clr_en
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (cfg_wr) begin
            en_d = cfg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign clr_en = en_q;

    p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (en_q == $past(cfg_val)));

endmodule

// File: rtl/sfc_access_decode.sv
module sfc_access_decode
    import sfc_pkg::*;
(
    input  logic    bus_rd,
    input  logic    bus_wr,
    input  logic    reg_sel,
    input  logic    brk_i,
    input  logic    clr_en,
    output access_t acc
);
    logic status_rd;
    logic data_acc;

    always_comb begin
        status_rd   = bus_rd && (reg_sel == SEL_STATUS);
        data_acc    = (bus_rd || bus_wr) && (reg_sel == SEL_DATA);
        acc.gate_ok = !brk_i || clr_en;
        acc.arm_stb = status_rd && acc.gate_ok;
        acc.clr_stb = data_acc && acc.gate_ok;
    end

endmodule

// File: rtl/sfc_flag_cell.sv
module sfc_flag_cell
    import sfc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    set_i,
    input  access_t acc,
    output logic    flag_o
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc.arm_stb) begin
            st_d.arm = st_q.flag;
        end
        if (acc.clr_stb && st_q.arm) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (st_q.flag && !st_q.arm));

    p_clear_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm) |=> st_q.flag);

    p_arm_from_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.arm) |-> $past(st_q.flag));

    p_no_arm_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc.gate_ok && !st_q.arm) |=> !st_q.arm);

    p_arm_kept_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc.gate_ok && st_q.arm && !set_i) |=> st_q.arm);

endmodule

// File: rtl/sfc_status_unit.sv
module sfc_status_unit
    import sfc_pkg::*;
#(
    parameter int NUM_FLAGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic                 reg_sel,
    input  logic                 brk_i,
    input  logic                 cfg_wr,
    input  logic                 cfg_val,
    output logic                 clr_en_o,
    output logic [NUM_FLAGS-1:0] flags_o
);
    localparam int FLAG_MSB = NUM_FLAGS - 1;

    logic    clr_en;
    access_t acc;

    sfc_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_val (cfg_val),
        .clr_en  (clr_en)
    );

    sfc_access_decode u_dec (
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .reg_sel (reg_sel),
        .brk_i   (brk_i),
        .clr_en  (clr_en),
        .acc     (acc)
    );

    for (genvar i = 0; i <= FLAG_MSB; i++) begin : g_cell
        sfc_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_evt[i]),
            .acc    (acc),
            .flag_o (flags_o[i])
        );
    end

    assign clr_en_o = clr_en;

    p_frozen_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !clr_en && (set_evt == '0)) |=> (flags_o == $past(flags_o)));

    p_set_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt != '0) |=> ((flags_o & $past(set_evt)) == $past(set_evt)));

endmodule

// File: tb/tb_sfc_status_unit.sv
`timescale 1ns/100ps
module tb_sfc_status_unit;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] set_evt = '0;
    logic         bus_rd = 1'b0, bus_wr = 1'b0, reg_sel = 1'b0, brk_i = 1'b0;
    logic         cfg_wr = 1'b0, cfg_val = 1'b0;
    logic         clr_en_o;
    logic [N-1:0] flags_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sfc_status_unit #(.NUM_FLAGS(N)) dut (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .reg_sel(reg_sel), .brk_i(brk_i), .cfg_wr(cfg_wr),
        .cfg_val(cfg_val), .clr_en_o(clr_en_o), .flags_o(flags_o)
    );

    // Row: [19:16] req, [15:12] set, [11] rd, [10] wr, [9] sel (0 status, 1 data),
    // [8] brk, [7] cfg_wr, [6] cfg_val, [3:0] expected flags after the edge.
    localparam int NV = 26;
    localparam logic [19:0] VEC [NV] = '{
        {4'd1,  4'b0011, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0011}, // R1 set
        {4'd3,  4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0011}, // R3 status read
        {4'd3,  4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0000}, // R3 data write clears
        {4'd1,  4'b0100, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}, // R1
        {4'd6,  4'b0000, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 2'b00, 4'b0100}, // R6 read in frozen break
        {4'd5,  4'b0000, 1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0, 2'b00, 4'b0100}, // R5 data read frozen
        {4'd6,  4'b0000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}, // R6 not armed
        {4'd7,  4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}, // R7 arm before break
        {4'd5,  4'b0000, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0, 2'b00, 4'b0100}, // R5 write frozen
        {4'd7,  4'b0000, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 2'b00, 4'b0100}, // R7 still frozen
        {4'd7,  4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0000}, // R7 completes after
        {4'd4,  4'b1000, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 2'b00, 4'b1000}, // R4 enable=1
        {4'd8,  4'b0000, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 2'b00, 4'b1000}, // R8 arm in break
        {4'd8,  4'b0000, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0, 2'b00, 4'b0000}, // R8 clear in break
        {4'd8,  4'b0000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0000}, // R8 stays clear
        {4'd1,  4'b0001, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0001}, // R1
        {4'd9,  4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0001}, // R9 arm
        {4'd9,  4'b0001, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0001}, // R9 set wins
        {4'd9,  4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0001}, // R9 arm cancelled
        {4'd10, 4'b0010, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0011}, // R10 set with read
        {4'd10, 4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0010}, // R10 old only
        {4'd10, 4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0010}, // R10 arm bit 1
        {4'd10, 4'b0100, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0110}, // R10 late set
        {4'd10, 4'b0000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}, // R10 armed only
        {4'd10, 4'b0000, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}, // R10 status write
        {4'd10, 4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0100}  // R10 no arm
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [19:0] v);
        set_evt = v[15:12]; bus_rd = v[11]; bus_wr = v[10];
        reg_sel = v[9]; brk_i = v[8]; cfg_wr = v[7]; cfg_val = v[6];
        @(negedge clk);
        set_evt = '0; bus_rd = 0; bus_wr = 0; cfg_wr = 0; cfg_val = 0;
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2 flags", flags_o, '0);
        check("R2 clr_en", {3'b0, clr_en_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            step(VEC[k]);
            check($sformatf("R%0d row %0d", VEC[k][19:16], k), flags_o, VEC[k][3:0]);
        end
        brk_i = 1'b0;
        // R4 enable reads back 1, then load 0
        check("R4 enable=1", {3'b0, clr_en_o}, 4'b0001);
        step({4'd4, 4'b0000, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 2'b00, 4'b0000});
        check("R4 enable=0", {3'b0, clr_en_o}, 4'b0000);
        // R2 reset drops arm bits: arm flag 2, reset, set again, data access
        step({4'd2, 4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 flags after reset", flags_o, '0);
        rst_n = 1'b1;
        step({4'd2, 4'b0100, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        step({4'd2, 4'b0000, 1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        check("R2 arm cleared by reset", flags_o, 4'b0100);
        // R3 clear by data read of all flags
        step({4'd3, 4'b1011, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        step({4'd3, 4'b0000, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        step({4'd3, 4'b0000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 2'b00, 4'b0000});
        check("R3 all cleared by data read", flags_o, 4'b0000);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule